// File: doc/BRIEF.md
# Framed Synchronous Serial Slot Engine

This block is the bit-level core of a master-mode synchronous serial port. It cuts the serial stream into repeating frames, one bit per clock, and places a data slot at the start of every frame. In the 16-bit frame codes that have room for one, a control slot follows the data slot. A frame-sync pulse marks the end of each frame. Its active level is selectable. Words to send are handed in through two valid/ready holding registers, one for data and one for control. Each slot takes its word at the moment the slot begins.

One serial line carries the transmitted bits out and another brings received bits in, sampled at the same slot positions. A completed data slot is presented as a parallel word with a one-cycle valid pulse. A completed control slot updates a held control word. Its valid pulse fires on every reception or only when the word changes, depending on a mode input. Whenever a bit time carries no loaded slot, or the engine is disabled, the output line either drives 1 or releases its output enable, depending on a select input.

A 4-bit code selects both the word width and the frame length. The code may be changed only while the engine is disabled. Raising the enable starts a new frame.

Top module: `fss_slot_engine`

## Requirements
- R1: The code `fl_code` sets the data width and the frame length. Bit 3 at 0 gives an 8-bit word and at 1 a 16-bit word. With bit 2 at 0 the frame is as long as the word. With bit 2 at 1 the frame is 16 bits (8-bit word) or 32 bits (16-bit word), shifted left by `fl_code[1:0]`. The frame therefore ranges from 8 to 256 bit times.
- R2: The data slot covers frame bits 0 to width-1 and is sent most-significant bit first. In 8-bit mode the word comes from `tx_data[7:0]`.
- R3: A control slot exists only for codes 11xx. It covers frame bits 16 to 31 and is sent MSB first. For every other code `tx_ctl_ready` stays 0 and `rx_ctl_valid` never rises.
- R4: In any bit time that carries no loaded slot, and whenever the engine is disabled, the output behaves as follows. With `idle_hiz`=0, `sdo`=1 and `sdo_oe`=1. With `idle_hiz`=1, `sdo_oe`=0.
- R5: `fsync` is active for exactly one bit time, the last bit of each frame, just before bit 0. Its active level is 1 when `sync_pol`=0 and 0 when `sync_pol`=1.
- R6: The bit time after `en` is first seen high is a sync bit with no slot. The next bit time is frame bit 0.
- R7: Each ready output is high exactly while its holding register is empty. A slot whose holding register is empty when the slot starts is idle (R4) for that frame.
- R8: `rx_data_valid` pulses for one cycle in the bit time after the last data-slot bit. `rx_data` then holds the received bits, zero-extended in 8-bit mode. No pulse follows the enable sync bit.
- R9: After bit 31 of a control frame, `rx_ctl` takes the received word. With `ctl_every`=1, `rx_ctl_valid` pulses on every such reception. With `ctl_every`=0, it pulses only when the new word differs from the held one.
- R10: After reset the state is as follows. Sync is inactive, the output is idle, no valid pulses are present, `tx_data_ready`=1, and `tx_ctl_ready` is 1 exactly for codes 11xx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Engine enable |
| fl_code | input | 4 | Width and frame-length code |
| idle_hiz | input | 1 | Idle output select: 0 drive 1, 1 release |
| sync_pol | input | 1 | Sync polarity: 0 active-high, 1 active-low |
| ctl_every | input | 1 | Control valid on every reception when 1 |
| tx_data_valid | input | 1 | Data word offered |
| tx_data | input | 16 | Data word to send |
| tx_data_ready | output | 1 | Data holding register empty |
| tx_ctl_valid | input | 1 | Control word offered |
| tx_ctl | input | 16 | Control word to send |
| tx_ctl_ready | output | 1 | Control holding register empty and slot present |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| fsync | output | 1 | Frame sync pulse |
| sdi | input | 1 | Serial data in |
| rx_data | output | 16 | Last received data word |
| rx_data_valid | output | 1 | One-cycle pulse on data reception |
| rx_ctl | output | 16 | Held received control word |
| rx_ctl_valid | output | 1 | Control reception pulse |

## Verification
The hardest case to reach is the change-only control flag. It needs one frame that repeats the held control word and a later frame that differs from it. It also needs idle control slots, which receive all ones. The bench loops the output line back to the input, with idle bits read as 1, and feeds a short list of control words in which two consecutive entries are equal. Once the list runs out, the control slots go idle. Every code is run once with the held-value mode and once with the every-reception mode, so all three cases appear in each run: a repeated word, a changed word and a run of idle slots.

// File: rtl/fss_pkg.sv
package fss_pkg;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned CNT_W    = 8;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned NARROW_W = 8;
  localparam int unsigned CTL_LO   = 16;
  localparam int unsigned CTL_HI   = 32;

  typedef struct packed {
    logic             wide;
    logic             has_ctl;
    logic [CNT_W-1:0] last;
    logic [CNT_W-1:0] dlen;
  } frame_cfg_t;

  function automatic frame_cfg_t decode_code(input logic [CODE_W-1:0] code);
    frame_cfg_t   r;
    logic [CNT_W:0] len;
    r.wide    = code[3];
    r.has_ctl = code[3] & code[2];
    r.dlen    = code[3] ? CNT_W'(WORD_W) : CNT_W'(NARROW_W);
    if (!code[2])
      len = code[3] ? (CNT_W+1)'(WORD_W) : (CNT_W+1)'(NARROW_W);
    else
      len = (code[3] ? (CNT_W+1)'(2*WORD_W) : (CNT_W+1)'(2*NARROW_W)) << code[1:0];
    r.last = CNT_W'(len - (CNT_W+1)'(1));
    return r;
  endfunction
endpackage

// File: rtl/fss_frame_timer.sv
module fss_frame_timer
  import fss_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] last,
  output logic             run_q,
  output logic             pre_q,
  output logic             fs_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             adv
);
  assign cnt_nxt = (cnt_q == last) ? '0 : cnt_q + CNT_W'(1);
  assign adv     = run_q & en;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      pre_q <= 1'b0;
      fs_q  <= 1'b0;
      cnt_q <= '0;
    end else if (!en) begin
      run_q <= 1'b0;
      pre_q <= 1'b0;
      fs_q  <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q) begin
      // first bit time after enable: sync only, then frame bit 0
      run_q <= 1'b1;
      pre_q <= 1'b1;
      fs_q  <= 1'b1;
      cnt_q <= last;
    end else begin
      pre_q <= 1'b0;
      cnt_q <= cnt_nxt;
      fs_q  <= (cnt_nxt == last);
    end
  end
endmodule

// File: rtl/fss_tx_slot.sv
module fss_tx_slot
  import fss_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              adv,
  input  logic [CNT_W-1:0]  cnt_nxt,
  input  frame_cfg_t        cfg,
  input  logic              tx_data_valid,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_data_ready,
  input  logic              tx_ctl_valid,
  input  logic [WORD_W-1:0] tx_ctl,
  output logic              tx_ctl_ready,
  output logic              live_q,
  output logic              bit_q
);
  logic [WORD_W-1:0] d_hold, c_hold, sh;
  logic              d_full, c_full;
  logic              d_acc, c_acc;
  logic [WORD_W-1:0] d_aligned;

  assign tx_data_ready = ~d_full;
  assign tx_ctl_ready  = cfg.has_ctl & ~c_full;
  assign d_acc         = tx_data_valid & tx_data_ready;
  assign c_acc         = tx_ctl_valid & tx_ctl_ready;
  assign d_aligned     = cfg.wide ? d_hold
                                  : {d_hold[NARROW_W-1:0], {(WORD_W-NARROW_W){1'b0}}};
  assign bit_q         = sh[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      d_hold <= '0;
      c_hold <= '0;
      sh     <= '0;
      d_full <= 1'b0;
      c_full <= 1'b0;
      live_q <= 1'b0;
    end else begin
      if (d_acc) begin
        d_hold <= tx_data;
        d_full <= 1'b1;
      end
      if (c_acc) begin
        c_hold <= tx_ctl;
        c_full <= 1'b1;
      end
      if (!en) begin
        live_q <= 1'b0;
      end else if (adv) begin
        if (cnt_nxt == '0) begin
          live_q <= d_full;
          if (d_full) begin
            sh     <= d_aligned;
            d_full <= 1'b0;
          end
        end else if (cfg.has_ctl && cnt_nxt == CNT_W'(CTL_LO)) begin
          live_q <= c_full;
          if (c_full) begin
            sh     <= c_hold;
            c_full <= 1'b0;
          end
        end else if (cnt_nxt == cfg.dlen || cnt_nxt == CNT_W'(CTL_HI)) begin
          live_q <= 1'b0;
        end else begin
          sh <= {sh[WORD_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/fss_rx_slot.sv
module fss_rx_slot
  import fss_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [CNT_W-1:0]  cnt_q,
  input  frame_cfg_t        cfg,
  input  logic              ctl_every,
  input  logic              sdi,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_data_valid,
  output logic [WORD_W-1:0] rx_ctl,
  output logic              rx_ctl_valid
);
  logic [WORD_W-1:0] rsh, word_in;
  logic              d_end, c_end;

  assign word_in = {rsh[WORD_W-2:0], sdi};
  assign d_end   = take && (cnt_q == cfg.dlen - CNT_W'(1));
  assign c_end   = take && cfg.has_ctl && (cnt_q == CNT_W'(CTL_HI - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsh           <= '0;
      rx_data       <= '0;
      rx_data_valid <= 1'b0;
      rx_ctl        <= '0;
      rx_ctl_valid  <= 1'b0;
    end else begin
      rsh           <= word_in;
      rx_data_valid <= d_end;
      rx_ctl_valid  <= c_end && (ctl_every || word_in != rx_ctl);
      if (d_end)
        rx_data <= cfg.wide ? word_in
                            : {{(WORD_W-NARROW_W){1'b0}}, word_in[NARROW_W-1:0]};
      if (c_end)
        rx_ctl <= word_in;
    end
  end
endmodule

// File: rtl/fss_slot_engine.sv
module fss_slot_engine
  import fss_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CODE_W-1:0] fl_code,
  input  logic              idle_hiz,
  input  logic              sync_pol,
  input  logic              ctl_every,
  input  logic              tx_data_valid,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_data_ready,
  input  logic              tx_ctl_valid,
  input  logic [WORD_W-1:0] tx_ctl,
  output logic              tx_ctl_ready,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              fsync,
  input  logic              sdi,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_data_valid,
  output logic [WORD_W-1:0] rx_ctl,
  output logic              rx_ctl_valid
);
  frame_cfg_t       cfg;
  logic             run_q, pre_q, fs_q, adv, live_q, bit_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  assign cfg = decode_code(fl_code);

  fss_frame_timer timer_i (
    .clk(clk), .rst(rst), .en(en), .last(cfg.last),
    .run_q(run_q), .pre_q(pre_q), .fs_q(fs_q),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .adv(adv)
  );

  fss_tx_slot tx_i (
    .clk(clk), .rst(rst), .en(en), .adv(adv), .cnt_nxt(cnt_nxt), .cfg(cfg),
    .tx_data_valid(tx_data_valid), .tx_data(tx_data), .tx_data_ready(tx_data_ready),
    .tx_ctl_valid(tx_ctl_valid), .tx_ctl(tx_ctl), .tx_ctl_ready(tx_ctl_ready),
    .live_q(live_q), .bit_q(bit_q)
  );

  fss_rx_slot rx_i (
    .clk(clk), .rst(rst), .take(run_q & ~pre_q), .cnt_q(cnt_q), .cfg(cfg),
    .ctl_every(ctl_every), .sdi(sdi),
    .rx_data(rx_data), .rx_data_valid(rx_data_valid),
    .rx_ctl(rx_ctl), .rx_ctl_valid(rx_ctl_valid)
  );

  assign sdo    = live_q ? bit_q : 1'b1;
  assign sdo_oe = live_q | ~idle_hiz;
  assign fsync  = fs_q ^ sync_pol;
endmodule

// File: rtl/fss_slot_engine_chk.sv
module fss_slot_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic [3:0] fl_code,
  input logic       idle_hiz,
  input logic       sync_pol,
  input logic       tx_data_valid,
  input logic       tx_data_ready,
  input logic       sdo,
  input logic       sdo_oe,
  input logic       fsync,
  input logic       rx_data_valid,
  input logic       rx_ctl_valid
);
  AST_SYNC_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    (fsync != sync_pol) |=> (fsync == sync_pol)); // R5

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!en && $past(!en)) |-> (sdo_oe == !idle_hiz) && (idle_hiz || sdo)); // R4

  AST_NO_CTL_NARROW: assert property (@(posedge clk) disable iff (rst)
    !fl_code[3] |-> !rx_ctl_valid); // R3

  AST_HOLD_FILLS: assert property (@(posedge clk) disable iff (rst)
    (tx_data_valid && tx_data_ready) |=> !tx_data_ready); // R7

  AST_RX_PULSE: assert property (@(posedge clk) disable iff (rst)
    rx_data_valid |=> !rx_data_valid); // R8
endmodule

bind fss_slot_engine fss_slot_engine_chk chk_i (
  .clk(clk), .rst(rst), .en(en), .fl_code(fl_code), .idle_hiz(idle_hiz),
  .sync_pol(sync_pol), .tx_data_valid(tx_data_valid), .tx_data_ready(tx_data_ready),
  .sdo(sdo), .sdo_oe(sdo_oe), .fsync(fsync),
  .rx_data_valid(rx_data_valid), .rx_ctl_valid(rx_ctl_valid)
);

// File: tb/fss_slot_engine_tb_top.sv
`timescale 1ns/1ps
module fss_slot_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1, en = 1'b0;
  logic [3:0]  fl_code = '0;
  logic        idle_hiz = 1'b0, sync_pol = 1'b0, ctl_every = 1'b0;
  logic        tx_data_valid = 1'b0, tx_ctl_valid = 1'b0;
  logic [15:0] tx_data = '0, tx_ctl = '0;
  logic        tx_data_ready, tx_ctl_ready, sdo, sdo_oe, fsync, sdi;
  logic [15:0] rx_data, rx_ctl;
  logic        rx_data_valid, rx_ctl_valid;

  always #2 clk = ~clk;
  assign sdi = sdo_oe ? sdo : 1'b1;

  fss_slot_engine dut_i (
    .clk(clk), .rst(rst), .en(en), .fl_code(fl_code), .idle_hiz(idle_hiz),
    .sync_pol(sync_pol), .ctl_every(ctl_every),
    .tx_data_valid(tx_data_valid), .tx_data(tx_data), .tx_data_ready(tx_data_ready),
    .tx_ctl_valid(tx_ctl_valid), .tx_ctl(tx_ctl), .tx_ctl_ready(tx_ctl_ready),
    .sdo(sdo), .sdo_oe(sdo_oe), .fsync(fsync), .sdi(sdi),
    .rx_data(rx_data), .rx_data_valid(rx_data_valid),
    .rx_ctl(rx_ctl), .rx_ctl_valid(rx_ctl_valid)
  );

  localparam int NW = 4, NC = 3, NF = 6;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  bit feed_on = 1'b0;
  int d_idx, c_idx;
  bit pv_d, pr_d, pv_c, pr_c;
  int pf, pb;
  bit ppre;
  logic [15:0] last_c;

  function automatic logic [15:0] dword(int code, int f);
    return 16'(f * 965 + 2465 + code * 273);
  endfunction
  function automatic logic [15:0] cword(int k);
    return 16'hC30F ^ 16'((k / 2) * 4951);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(int code);
    @(negedge clk);
    if (pv_d && pr_d) d_idx++;
    if (pv_c && pr_c) c_idx++;
    tx_data_valid = feed_on && (d_idx < NW);
    tx_data       = dword(code, d_idx);
    tx_ctl_valid  = feed_on && (c_idx < NC);
    tx_ctl        = cword(c_idx);
    pv_d = tx_data_valid; pr_d = tx_data_ready;
    pv_c = tx_ctl_valid;  pr_c = tx_ctl_ready;
  endtask

  // one bit-time check; f<0 / pre marks the enable sync bit
  task automatic sample(int code, int f, int b, bit pre);
    int dw, flen;
    bit hc, ed, ec, ebit, edv, ecv;
    logic [15:0] w, rw;
    dw   = code[3] ? 16 : 8;
    flen = !code[2] ? dw : ((code[3] ? 32 : 16) << code[1:0]);
    hc   = code[3] && code[2];
    // R1 R5 R6: sync active only in the last bit of a frame
    chk(fsync == (((b == flen - 1) ? 1'b1 : 1'b0) ^ sync_pol), pre ? "R6 sync bit" : "R5 R1 fsync", fsync, ((b == flen - 1) ? 1 : 0) ^ sync_pol);
    ed = !pre && b < dw && f < NW;
    ec = !pre && hc && b >= 16 && b < 32 && f < NC;
    ebit = 1'b1;
    if (ed) begin w = dword(code, f); ebit = w[dw - 1 - b]; end
    if (ec) begin w = cword(f); ebit = w[31 - b]; end
    if (ed || ec) begin
      chk(sdo_oe == 1'b1, ed ? "R2 slot oe" : "R3 slot oe", sdo_oe, 1);
      chk(sdo == ebit, ed ? "R2 data bit" : "R3 ctl bit", sdo, ebit);
    end else begin
      chk(sdo_oe == !idle_hiz, "R4 R7 idle oe", sdo_oe, !idle_hiz);
      if (!idle_hiz) chk(sdo == 1'b1, "R4 R7 idle level", sdo, 1);
    end
    if (!hc) chk(tx_ctl_ready == 1'b0, "R3 ctl ready", tx_ctl_ready, 0);
    // receive side, from the previous bit time
    edv = !pre && !ppre && (pb == dw - 1);
    chk(rx_data_valid == edv, "R8 rx_data_valid", rx_data_valid, edv);
    if (edv) begin
      rw = (pf < NW) ? dword(code, pf) : 16'hFFFF;
      if (!code[3]) rw = rw & 16'h00FF;
      chk(rx_data == rw, "R8 rx_data", rx_data, rw);
    end
    if (hc && !pre && !ppre && pb == 31) begin
      rw  = (pf < NC) ? cword(pf) : 16'hFFFF;
      ecv = ctl_every || (rw != last_c);
      chk(rx_ctl_valid == ecv, "R9 rx_ctl_valid", rx_ctl_valid, ecv);
      chk(rx_ctl == rw, "R9 rx_ctl", rx_ctl, rw);
      last_c = rw;
    end else begin
      chk(rx_ctl_valid == 1'b0, hc ? "R9 no ctl pulse" : "R3 no ctl pulse", rx_ctl_valid, 0);
    end
    pf = f; pb = b; ppre = pre;
  endtask

  task automatic run_cfg(int code, bit hz, bit pol, bit every);
    int flen;
    flen = !code[2] ? (code[3] ? 16 : 8) : ((code[3] ? 32 : 16) << code[1:0]);
    feed_on = 1'b0;
    tick(code);
    rst = 1'b1; en = 1'b0;
    fl_code = 4'(code); idle_hiz = hz; sync_pol = pol; ctl_every = every;
    d_idx = 0; c_idx = 0; pv_d = 0; pv_c = 0; pr_d = 0; pr_c = 0;
    last_c = 16'h0000;
    repeat (3) tick(code);
    rst = 1'b0;
    tick(code);
    // R10: reset state
    chk(fsync == pol, "R10 sync idle", fsync, pol);
    chk(sdo_oe == !hz, "R10 oe", sdo_oe, !hz);
    chk(rx_data_valid == 1'b0 && rx_ctl_valid == 1'b0, "R10 valids", {rx_data_valid, rx_ctl_valid}, 0);
    chk(tx_data_ready == 1'b1, "R10 data ready", tx_data_ready, 1);
    chk(tx_ctl_ready == (code[3] && code[2]), "R10 ctl ready", tx_ctl_ready, code[3] && code[2]);
    feed_on = 1'b1;
    repeat (3) tick(code);
    en = 1'b1;
    ppre = 1'b1; pf = -1; pb = -1;
    tick(code);
    sample(code, -1, flen - 1, 1'b1);
    for (int f = 0; f < NF; f++)
      for (int b = 0; b < flen; b++) begin
        tick(code);
        sample(code, f, b, 1'b0);
      end
    en = 1'b0;
    tick(code);
    // R4: disabled output
    chk(sdo_oe == !hz, "R4 disabled oe", sdo_oe, !hz);
    if (!hz) chk(sdo == 1'b1, "R4 disabled level", sdo, 1);
    chk(fsync == pol, "R5 sync off when disabled", fsync, pol);
  endtask

  initial begin
    for (int code = 0; code < 16; code++)
      for (int p = 0; p < 2; p++)
        run_cfg(code, p[0], p[0] ^ code[0], p[0] ^ code[1]);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule